// File: doc/BRIEF.md
# PCM Clock and Frame-Sync Generator

This block produces the timing a voice-band PCM codec port needs: a bit clock, an 8 kHz frame-sync pulse and a master clock. All three come from a single core clock. The core clock runs at 8.192 MHz, which is twice the 4.096 MHz reference, so that a bit clock at the full reference rate can still be built from registered logic. One frame lasts 1024 core cycles.

The bit-clock rate, the frame-sync width and the master-clock source are static configuration pins. The block samples them only at the edge that starts a frame. The 1-bit-wide pulse gives short sync and the wider settings give long sync. Every output comes straight from a flop. The outputs stay low while reset is active. They begin a full frame on the first core-clock edge after reset is released.

Top module: `pcm_timing_gen`

## Requirements
- R1: While `rst_n_i` is low, `bclk_o`, `fsync_o` and `mclk_o` are all 0. The first rising core-clock edge after release is tick 0 of a frame.
- R2: A frame is 1024 core cycles. `bclk_o` is high for the first half of each bit period and low for the second half. The bit period in core cycles depends on `rate_sel_i`: code 0 gives 2, code 1 gives 4, code 2 gives 8, code 3 gives 16, code 4 gives 64 and code 5 gives 128. These are 4.096 MHz, 2.048 MHz, 1.024 MHz, 512 kHz, 128 kHz and 64 kHz.
- R3: `rate_sel_i` codes 6 and 7 behave exactly like code 1 (4-cycle bit period).
- R4: `fsync_o` rises at tick 0 of every frame, in the same cycle in which `bclk_o` rises.
- R5: `fsync_o` stays high for (`fs_width_i` + 1) whole bit periods from the frame start, then stays low for the rest of the frame. Code 0 is short sync; codes 1 to 7 are long sync.
- R6: If the requested width is not less than the number of bit periods in a frame, the width is cut to that number minus one. At code 5 (8 bits per frame), width code 7 therefore gives 7 bit periods. `fsync_o` is always low at tick 1023.
- R7: `mclk_o` follows `bclk_o` when `mclk_sel_i` is 1. When it is 0, `mclk_o` is a 256 kHz square wave: a 32-core-cycle period, high for the first 16 cycles of each period, starting at tick 0.
- R8: `rate_sel_i`, `fs_width_i` and `mclk_sel_i` are read only at the edge that enters tick 0. A change made in the middle of a frame has no effect on any output until the next frame begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_core_i | input | 1 | 8.192 MHz core clock, twice the reference |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously |
| rate_sel_i | input | 3 | Bit-clock rate code |
| fs_width_i | input | 3 | Frame-sync width code, n means n+1 bit periods |
| mclk_sel_i | input | 1 | Master-clock source: 0 fixed 256 kHz, 1 bit clock |
| bclk_o | output | 1 | Bit clock |
| fsync_o | output | 1 | Frame-sync pulse, one per 1024 core cycles |
| mclk_o | output | 1 | Master clock |

## Verification
The bench targets the 64 kHz rate with the widest width code. A design without the clamp would hold sync high across the frame boundary and never show an 8 kHz edge. It also targets the reserved rate codes: a design that decoded them literally would produce an odd bit period. Mid-frame configuration changes are placed at random ticks. A design that applied them at once would cut the current sync pulse short or stretch it, or would cut the bit-clock half period short. The reset-to-first-frame step is checked as well. A counter started one tick out of phase would move every edge by one cycle, and the bench compares every output in every cycle.

// File: rtl/pcm_tg_pkg.sv
package pcm_tg_pkg;

  localparam int unsigned CODE_W = 3;

  // Active configuration, decoded once per frame.
  typedef struct packed {
    logic [2:0] half_exp;   // log2 of bit-clock half period in core cycles
    logic [9:0] width_bits; // sync width in bit periods, already clamped
    logic       mclk_bclk;  // 1: master clock follows bit clock
  } tg_cfg_t;

  // Rate code to half-period exponent; reserved codes map to the 2.048 MHz rate.
  function automatic logic [2:0] rate_half_exp(input logic [CODE_W-1:0] code);
    logic [2:0] e;
    case (code)
      3'd0:    e = 3'd0;
      3'd1:    e = 3'd1;
      3'd2:    e = 3'd2;
      3'd3:    e = 3'd3;
      3'd4:    e = 3'd5;
      3'd5:    e = 3'd6;
      default: e = 3'd1;
    endcase
    return e;
  endfunction

endpackage

// File: rtl/pcm_frame_ctr.sv
module pcm_frame_ctr #(
  parameter int unsigned FRAME_TICKS = 1024,
  localparam int unsigned TW = $clog2(FRAME_TICKS)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [TW-1:0] tick_q,
  output logic [TW-1:0] tick_d,
  output logic          frame_start
);

  localparam logic [TW-1:0] LAST = TW'(FRAME_TICKS - 1);

  // Next-state logic
  always_comb begin
    if (tick_q == LAST) tick_d = '0;
    else                tick_d = tick_q + TW'(1);
    frame_start = (tick_d == '0);
  end

  // Register; reset parks on the last tick so the first edge opens a frame
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_q <= LAST;
    else        tick_q <= tick_d;
  end

  a_r2_tick_range: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q <= LAST);

  a_r2_tick_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_q == LAST) |=> (tick_q == '0));

endmodule

// File: rtl/pcm_cfg_latch.sv
module pcm_cfg_latch
  import pcm_tg_pkg::*;
#(
  parameter int unsigned FRAME_TICKS = 1024,
  localparam int unsigned TW = $clog2(FRAME_TICKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [CODE_W-1:0] rate_code,
  input  logic [CODE_W-1:0] width_code,
  input  logic              mclk_sel,
  output tg_cfg_t           cfg_d,
  output tg_cfg_t           cfg_q
);

  logic [2:0]    exp_dec;
  logic [TW-1:0] bits_per_frame;
  logic [TW-1:0] want_bits;
  tg_cfg_t       cfg_dec;

  // Decode and clamp the pin settings
  always_comb begin
    exp_dec        = rate_half_exp(rate_code);
    bits_per_frame = TW'(FRAME_TICKS >> ({1'b0, exp_dec} + 4'd1));
    want_bits      = TW'(width_code) + TW'(1);
    cfg_dec.half_exp  = exp_dec;
    cfg_dec.mclk_bclk = mclk_sel;
    if (want_bits >= bits_per_frame) cfg_dec.width_bits = 10'(bits_per_frame - TW'(1));
    else                             cfg_dec.width_bits = 10'(want_bits);
  end

  // Clock enable: only the frame-opening edge loads new settings
  always_comb begin
    if (load_en) cfg_d = cfg_dec;
    else         cfg_d = cfg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  a_r8_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(cfg_q));

endmodule

// File: rtl/pcm_wave_gen.sv
module pcm_wave_gen
  import pcm_tg_pkg::*;
#(
  parameter int unsigned FRAME_TICKS = 1024,
  parameter int unsigned MCLK_HALF_EXP = 4,
  localparam int unsigned TW = $clog2(FRAME_TICKS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] tick_d,
  input  logic [TW-1:0] tick_q,
  input  tg_cfg_t       cfg_d,
  output logic          bclk_q,
  output logic          fsync_q,
  output logic          mclk_q
);

  localparam logic [TW-1:0] LAST = TW'(FRAME_TICKS - 1);

  logic          bclk_n;
  logic          fsync_n;
  logic          mclk_n;
  logic [TW-1:0] bit_idx;

  // Next-state logic from the tick being entered
  always_comb begin
    bclk_n  = ~tick_d[cfg_d.half_exp];
    bit_idx = tick_d >> ({1'b0, cfg_d.half_exp} + 4'd1);
    fsync_n = (10'(bit_idx) < cfg_d.width_bits);
    if (cfg_d.mclk_bclk) mclk_n = bclk_n;
    else                 mclk_n = ~tick_d[MCLK_HALF_EXP];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q  <= 1'b0;
      fsync_q <= 1'b0;
      mclk_q  <= 1'b0;
    end else begin
      bclk_q  <= bclk_n;
      fsync_q <= fsync_n;
      mclk_q  <= mclk_n;
    end
  end

  a_r4_sync_rise_with_bclk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fsync_q) |-> $rose(bclk_q));

  a_r4_sync_rise_at_frame_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fsync_q) |-> (tick_q == '0));

  a_r5_sync_fall_on_bit_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fsync_q) |-> $rose(bclk_q));

  a_r6_sync_low_at_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_q == LAST) |-> !fsync_q);

endmodule

// File: rtl/pcm_timing_gen.sv
module pcm_timing_gen
  import pcm_tg_pkg::*;
#(
  parameter int unsigned FRAME_TICKS = 1024,
  parameter int unsigned MCLK_HALF_EXP = 4
) (
  input  logic              clk_core_i,
  input  logic              rst_n_i,
  input  logic [CODE_W-1:0] rate_sel_i,
  input  logic [CODE_W-1:0] fs_width_i,
  input  logic              mclk_sel_i,
  output logic              bclk_o,
  output logic              fsync_o,
  output logic              mclk_o
);

  localparam int unsigned TW = $clog2(FRAME_TICKS);

  logic [TW-1:0] tick_q;
  logic [TW-1:0] tick_d;
  logic          frame_start;
  tg_cfg_t       cfg_d;
  tg_cfg_t       cfg_q;

  pcm_frame_ctr #(.FRAME_TICKS(FRAME_TICKS)) i_frame_ctr (
    .clk         (clk_core_i),
    .rst_n       (rst_n_i),
    .tick_q      (tick_q),
    .tick_d      (tick_d),
    .frame_start (frame_start)
  );

  pcm_cfg_latch #(.FRAME_TICKS(FRAME_TICKS)) i_cfg_latch (
    .clk        (clk_core_i),
    .rst_n      (rst_n_i),
    .load_en    (frame_start),
    .rate_code  (rate_sel_i),
    .width_code (fs_width_i),
    .mclk_sel   (mclk_sel_i),
    .cfg_d      (cfg_d),
    .cfg_q      (cfg_q)
  );

  pcm_wave_gen #(
    .FRAME_TICKS   (FRAME_TICKS),
    .MCLK_HALF_EXP (MCLK_HALF_EXP)
  ) i_wave_gen (
    .clk     (clk_core_i),
    .rst_n   (rst_n_i),
    .tick_d  (tick_d),
    .tick_q  (tick_q),
    .cfg_d   (cfg_d),
    .bclk_q  (bclk_o),
    .fsync_q (fsync_o),
    .mclk_q  (mclk_o)
  );

  // R7: with bit-clock source selected, master clock tracks bit clock
  a_r7_mclk_tracks_bclk: assert property (@(posedge clk_core_i) disable iff (!rst_n_i)
    cfg_q.mclk_bclk |-> (mclk_o == bclk_o));

  // R1: outputs leave reset with a frame start
  a_r1_first_edge_opens_frame: assert property (@(posedge clk_core_i) disable iff (!rst_n_i)
    (tick_q == '0) |-> bclk_o);

endmodule

// File: tb/test_pcm_timing_gen.sv
module test_pcm_timing_gen;

  localparam int FRAME = 1024;

  logic       clk;
  logic       rst_n;
  logic [2:0] rate_sel;
  logic [2:0] fs_width;
  logic       mclk_sel;
  logic       bclk, fsync, mclk;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // bench model state
  int tm;
  bit started = 0;
  int m_rate, m_wid, m_sel;
  bit pend = 0;
  int fs_cnt = 0;

  pcm_timing_gen i_pcm_timing_gen (
    .clk_core_i (clk),
    .rst_n_i    (rst_n),
    .rate_sel_i (rate_sel),
    .fs_width_i (fs_width),
    .mclk_sel_i (mclk_sel),
    .bclk_o     (bclk),
    .fsync_o    (fsync),
    .mclk_o     (mclk)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Bit period in core cycles per R2/R3
  function automatic int bit_period(input int code);
    case (code)
      0: return 2;
      1: return 4;
      2: return 8;
      3: return 16;
      4: return 64;
      5: return 128;
      default: return 4;
    endcase
  endfunction

  // Sync width in bit periods per R5/R6
  function automatic int sync_bits(input int rcode, input int wcode);
    int per_frame = FRAME / bit_period(rcode);
    if (wcode + 1 >= per_frame) return per_frame - 1;
    return wcode + 1;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      if (bad <= 20)
        $display("FAIL %s tick=%0d actual=%0d expected=%0d", req, tm, act, exp);
    end
  endtask

  task automatic step();
    int bp;
    int e_bclk, e_fs, e_mclk;
    @(posedge clk);
    if (!started) begin tm = 0; started = 1; end
    else tm = (tm + 1) % FRAME;
    if (tm == 0) begin
      m_rate = rate_sel; m_wid = fs_width; m_sel = mclk_sel;
      pend = 0; fs_cnt = 0;
    end
    @(negedge clk);
    bp     = bit_period(m_rate);
    e_bclk = ((tm % bp) < bp / 2) ? 1 : 0;
    e_fs   = ((tm / bp) < sync_bits(m_rate, m_wid)) ? 1 : 0;
    e_mclk = (m_sel != 0) ? e_bclk : (((tm % 32) < 16) ? 1 : 0);
    chk(pend ? "R8 bclk" : "R2 R3 bclk", int'(bclk), e_bclk);
    chk(pend ? "R8 fsync" : "R4 R5 fsync", int'(fsync), e_fs);
    chk(pend ? "R8 mclk" : "R7 mclk", int'(mclk), e_mclk);
    if (fsync) fs_cnt++;
    if (tm == FRAME - 1) begin
      chk("R5 R6 sync length", fs_cnt, sync_bits(m_rate, m_wid) * bp);
      chk("R6 sync low at frame end", int'(fsync), 0);
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic set_cfg(input int r, input int w, input int s);
    rate_sel = 3'(r); fs_width = 3'(w); mclk_sel = 1'(s);
    if (started && tm != FRAME - 1) pend = 1;
  endtask

  initial begin
    void'($urandom(32'hC0DE));
    rst_n = 1'b0;
    rate_sel = 3'd5; fs_width = 3'd7; mclk_sel = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R1 reset bclk", int'(bclk), 0);
      chk("R1 reset fsync", int'(fsync), 0);
      chk("R1 reset mclk", int'(mclk), 0);
    end
    rst_n = 1'b1;
    // R1 R6: first frame after reset at 64 kHz with widest code (clamp to 7)
    run(FRAME);
    // directed: every rate code incl. reserved (R3), short and long sync
    for (int c = 0; c < 8; c++) begin
      run(300);
      set_cfg(c, c % 8, c % 2);
      run(FRAME * 2 - 300);
    end
    // R6 boundary neighbours: 128 kHz widest, 64 kHz width 7 unclamped
    set_cfg(4, 7, 1); run(FRAME * 2);
    set_cfg(5, 6, 0); run(FRAME * 2);
    set_cfg(0, 0, 1); run(FRAME * 2);
    // R8: random mid-frame changes
    for (int k = 0; k < 30; k++) begin
      run(int'($urandom_range(1, 1500)));
      set_cfg(int'($urandom_range(0, 7)), int'($urandom_range(0, 7)),
              int'($urandom_range(0, 1)));
    end
    run(FRAME * 2);
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule